// File: doc/BRIEF.md
# Barrel Shifter with Carry and Extend Flags

This block shifts a 32-bit operand left logically, right logically or right arithmetically by a count taken from a register. Alongside the shifted word it returns the carry-out flag and the extend flag that an integer execution stage writes into its condition state. It is purely combinational, so it sits inside a single execute cycle. The negative, zero and overflow flags are produced by a separate flag evaluator downstream.

Only the low six bits of the count matter. The behaviour falls into four count classes: zero, one to thirty-one, exactly thirty-two, and above thirty-two. A zero count, or the reserved shift kind, passes the operand through untouched and returns the incoming carry on both flag outputs. Every real nonzero shift copies its carry into the extend flag.

Top module: `shift_cx_unit`

## Requirements
- R1: Only bits [5:0] of `count_i` take part. Any value in the upper count bits gives the same outputs as the same low six bits with the upper bits clear.
- R2: With a masked count of zero and a non-reserved kind, `result_o` equals `operand_i`, and both `carry_o` and `extend_o` equal `carry_prev_i`.
- R3: With kind 2'b00 (logical left) and a count n from 1 to 31, `result_o` is `operand_i << n` with zero fill, and `carry_o` is operand bit 32-n.
- R4: With logical left and a count of exactly 32, `result_o` is zero and `carry_o` is operand bit 0. Above 32, both are zero.
- R5: With kind 2'b01 (logical right) and a count n from 1 to 31, `result_o` is `operand_i >> n` with zero fill, and `carry_o` is operand bit n-1.
- R6: With logical right and a count of exactly 32, `result_o` is zero and `carry_o` is operand bit 31. Above 32, both are zero.
- R7: With kind 2'b10 (arithmetic right) and a count n from 1 to 31, `result_o` is the operand shifted right with copies of bit 31 filled in, and `carry_o` is operand bit n-1.
- R8: With arithmetic right and a count of 32 or more, every bit of `result_o` equals operand bit 31, and so does `carry_o`.
- R9: For every nonzero masked count under kinds 00, 01 and 10, `extend_o` equals `carry_o`.
- R10: Kind 2'b11 is reserved. `result_o` equals `operand_i`, and both `carry_o` and `extend_o` equal `carry_prev_i`, whatever the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Word to be shifted |
| count_i | input | 32 | Shift count; only bits [5:0] are used |
| kind_i | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 reserved |
| carry_prev_i | input | 1 | Current carry flag, returned when nothing shifts |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Last bit shifted out, or the held carry |
| extend_o | output | 1 | Extend flag; follows the carry output |

## Verification
Immediate assertions beside the output logic check the pass-through rules continuously: the zero-count hold, the reserved kind, the one-bit left shift with its carry, the exact-32 logical right shift, the zeroing of large logical left shifts and the sign fill of large arithmetic right shifts. The bench sweeps every count from 0 to 63 for each kind over several operand patterns and compares the result against a reference model built on 64-bit arithmetic. Only this sweep shows the carry bit position for partial shifts and that the extend flag follows the carry. The bench also drives the count's upper bits, which only a direct comparison at the ports can show to be ignored.

// File: rtl/shift_cx_pkg.sv
// Shared types for the carry/extend shifter.
// Assumes: the shift kind is a 2-bit code decoded only by shift_cx_unit and its children.
package shift_cx_pkg;

    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_RSV = 2'b11
    } shift_kind_t;

    typedef enum logic [1:0] {
        CNT_ZERO = 2'd0,
        CNT_PART = 2'd1,
        CNT_FULL = 2'd2,
        CNT_OVER = 2'd3
    } cnt_class_t;

endpackage

// File: rtl/sh_count_class.sv
// Sorts a masked shift count into zero, partial (1..W-1), full (exactly W) or over (above W).
// Assumes: the count has log2(W)+1 bits and W is a power of two.
module sh_count_class
    import shift_cx_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] cnt_i,
    output cnt_class_t       cls_o,
    output logic [CNT_W-2:0] part_amt_o
);

    // Classify the count by its top bit and whether the remaining bits are zero.
    always_comb begin
        if (cnt_i == '0)
            cls_o = CNT_ZERO;
        else if (!cnt_i[CNT_W-1])
            cls_o = CNT_PART;
        else if (cnt_i[CNT_W-2:0] == '0)
            cls_o = CNT_FULL;
        else
            cls_o = CNT_OVER;
    end

    assign part_amt_o = cnt_i[CNT_W-2:0];

endmodule

// File: rtl/sh_log_barrel.sv
// Logarithmic barrel shifter for amounts 0..W-1. A left shift is done as a right shift
// of the bit-reversed word, which keeps a single stage chain for all three kinds.
// Assumes: fill_i is zero for logical shifts and the sign bit for arithmetic right.
module sh_log_barrel #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 5
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              left_i,
    input  logic              fill_i,
    output logic [DATA_W-1:0] shifted_o
);

    function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
        return r;
    endfunction

    logic [DATA_W-1:0] entry_w;
    logic [DATA_W-1:0] exit_w;

    // Reverse the operand on entry for a left shift.
    assign entry_w = left_i ? bit_rev(data_i) : data_i;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        logic [DATA_W-1:0] din;
        logic [DATA_W-1:0] dout;
        if (s == 0) begin : g_first
            assign din = entry_w;
        end else begin : g_next
            assign din = g_stage[s-1].dout;
        end
        // One stage: move right by 2**s when amount bit s is set.
        assign dout = amt_i[s] ? {{STEP{fill_i}}, din[DATA_W-1:STEP]} : din;
    end

    assign exit_w = g_stage[AMT_W-1].dout;

    // Undo the entry reversal for a left shift.
    assign shifted_o = left_i ? bit_rev(exit_w) : exit_w;

endmodule

// File: rtl/sh_carry_pick.sv
// Chooses the carry-out bit from the operand by shift kind and count class.
// Assumes: amt_i holds the low count bits and is nonzero whenever the class is partial.
module sh_carry_pick
    import shift_cx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 5
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  shift_kind_t       kind_i,
    input  cnt_class_t        cls_i,
    input  logic              carry_prev_i,
    output logic              carry_o
);

    localparam logic [AMT_W:0] DW_EXT = (AMT_W+1)'(DATA_W);

    logic [AMT_W:0]   left_idx;
    logic [AMT_W-1:0] right_idx;

    // Bit positions of the last bit shifted out for partial shifts.
    assign left_idx  = DW_EXT - {1'b0, amt_i};
    assign right_idx = amt_i - AMT_W'(1);

    // Select the carry per kind and count class; the reserved kind and a zero count hold it.
    always_comb begin
        carry_o = carry_prev_i;
        if (kind_i != SHK_RSV) begin
            unique case (cls_i)
                CNT_ZERO: carry_o = carry_prev_i;
                CNT_PART: carry_o = (kind_i == SHK_LSL) ? data_i[left_idx[AMT_W-1:0]]
                                                        : data_i[right_idx];
                CNT_FULL: carry_o = (kind_i == SHK_LSL) ? data_i[0] : data_i[DATA_W-1];
                CNT_OVER: carry_o = (kind_i == SHK_ASR) ? data_i[DATA_W-1] : 1'b0;
                default:  carry_o = carry_prev_i;
            endcase
        end
    end

endmodule

// File: rtl/shift_cx_unit.sv
// Top of the shifter: masks the count, classifies it, runs the barrel and the carry
// picker, and forms the result for counts at or beyond the word width.
// Assumes: DATA_W is a power of two; purely combinational, no clock or reset.
module shift_cx_unit
    import shift_cx_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CNT_IN_W = 32
) (
    input  logic [DATA_W-1:0]   operand_i,
    input  logic [CNT_IN_W-1:0] count_i,
    input  logic [1:0]          kind_i,
    input  logic                carry_prev_i,
    output logic [DATA_W-1:0]   result_o,
    output logic                carry_o,
    output logic                extend_o
);

    localparam int AMT_W = $clog2(DATA_W);
    localparam int CNT_W = AMT_W + 1;

    shift_kind_t       kind_w;
    cnt_class_t        cls_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [AMT_W-1:0]  amt_w;
    logic [DATA_W-1:0] barrel_w;
    logic              sign_w;

    assign kind_w = shift_kind_t'(kind_i);
    assign cnt_w  = count_i[CNT_W-1:0];
    assign sign_w = operand_i[DATA_W-1];

    if (CNT_IN_W > CNT_W) begin : g_cnt_hi
        logic unused_cnt_hi;
        assign unused_cnt_hi = ^count_i[CNT_IN_W-1:CNT_W];
    end

    sh_count_class #(.CNT_W(CNT_W)) u_class (
        .cnt_i      (cnt_w),
        .cls_o      (cls_w),
        .part_amt_o (amt_w)
    );

    sh_log_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_barrel (
        .data_i    (operand_i),
        .amt_i     (amt_w),
        .left_i    (kind_w == SHK_LSL),
        .fill_i    ((kind_w == SHK_ASR) & sign_w),
        .shifted_o (barrel_w)
    );

    sh_carry_pick #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_carry (
        .data_i       (operand_i),
        .amt_i        (amt_w),
        .kind_i       (kind_w),
        .cls_i        (cls_w),
        .carry_prev_i (carry_prev_i),
        .carry_o      (carry_o)
    );

    // Result: pass-through, barrel output, or full fill for counts of W and more.
    always_comb begin
        if (kind_w == SHK_RSV || cls_w == CNT_ZERO)
            result_o = operand_i;
        else if (cls_w == CNT_PART)
            result_o = barrel_w;
        else
            result_o = (kind_w == SHK_ASR) ? {DATA_W{sign_w}} : '0;
    end

    // Extend follows the carry; on a zero count or reserved kind that is the held carry.
    assign extend_o = carry_o;

    // Port-level checks on the pass-through and boundary rules.
    always_comb begin
        // R2
        zero_count_hold_chk: assert (!(cnt_w == '0 && kind_i != 2'b11) ||
            (result_o == operand_i && carry_o == carry_prev_i && extend_o == carry_prev_i));
        // R10
        rsvd_pass_chk: assert (kind_i != 2'b11 ||
            (result_o == operand_i && carry_o == carry_prev_i && extend_o == carry_prev_i));
        // R3
        lsl_one_chk: assert (!(kind_i == 2'b00 && cnt_w == CNT_W'(1)) ||
            (result_o == {operand_i[DATA_W-2:0], 1'b0} && carry_o == operand_i[DATA_W-1]));
        // R4
        lsl_over_zero_chk: assert (!(kind_i == 2'b00 && cnt_w > CNT_W'(DATA_W)) ||
            (result_o == '0 && carry_o == 1'b0));
        // R6
        lsr_full_chk: assert (!(kind_i == 2'b01 && cnt_w == CNT_W'(DATA_W)) ||
            (result_o == '0 && carry_o == operand_i[DATA_W-1]));
        // R8
        asr_sign_fill_chk: assert (!(kind_i == 2'b10 && cnt_w >= CNT_W'(DATA_W)) ||
            (result_o == {DATA_W{operand_i[DATA_W-1]}} && carry_o == operand_i[DATA_W-1]));
    end

endmodule

// File: tb/shift_cx_unit_test.sv
module shift_cx_unit_test;

    logic        clk = 1'b0;
    logic [31:0] operand;
    logic [31:0] count;
    logic [1:0]  kind;
    logic        cprev;
    logic [31:0] result;
    logic        carry;
    logic        extend;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    shift_cx_unit uut (
        .operand_i    (operand),
        .count_i      (count),
        .kind_i       (kind),
        .carry_prev_i (cprev),
        .result_o     (result),
        .carry_o      (carry),
        .extend_o     (extend)
    );

    // Reference model on 64-bit arithmetic.
    task automatic model(input logic [31:0] op, input logic [31:0] cnt_in, input logic [1:0] k,
                         input logic cp, output logic [31:0] r, output logic c);
        int n;
        logic [63:0] w;
        n = int'(cnt_in[5:0]);
        if (k == 2'b11 || n == 0) begin
            r = op; c = cp;
        end else if (k == 2'b00) begin
            w = {32'h0, op} << n;
            r = w[31:0];
            c = (n <= 32) ? w[32] : 1'b0;
        end else if (k == 2'b01) begin
            w = {op, 32'h0} >> n;
            r = w[63:32]; c = w[31];
        end else begin
            w = 64'($signed({op, 32'h0}) >>> n);
            r = w[63:32]; c = w[31];
        end
    endtask

    function automatic string tag_for(input logic [1:0] k, input int n);
        if (k == 2'b11) return "R10";
        if (n == 0)     return "R2";
        case (k)
            2'b00:   return (n < 32) ? "R3" : "R4";
            2'b01:   return (n < 32) ? "R5" : "R6";
            default: return (n < 32) ? "R7" : "R8";
        endcase
    endfunction

    task automatic apply_and_check(input logic [31:0] op, input logic [31:0] cnt_in,
                                   input logic [1:0] k, input logic cp, input string tag);
        logic [31:0] er;
        logic        ec;
        @(negedge clk);
        operand = op; count = cnt_in; kind = k; cprev = cp;
        #1;
        model(op, cnt_in, k, cp, er, ec);
        checks++;
        if (result !== er || carry !== ec) begin
            failures++;
            $display("FAIL %s op=%h cnt=%0d kind=%b: result=%h carry=%b expected result=%h carry=%b",
                     tag, op, cnt_in, k, result, carry, er, ec);
        end
        checks++;
        if (extend !== ec) begin
            failures++;
            $display("FAIL R9 op=%h cnt=%0d kind=%b: extend=%b expected %b",
                     op, cnt_in, k, extend, ec);
        end
    endtask

    // Idle state with all inputs zero.
    task automatic t_idle_state();
        @(negedge clk);
        operand = '0; count = '0; kind = 2'b00; cprev = 1'b0;
        #1;
        checks++;
        if (result !== 32'h0 || carry !== 1'b0 || extend !== 1'b0) begin
            failures++;
            $display("FAIL R2 idle: result=%h carry=%b extend=%b expected 0 0 0",
                     result, carry, extend);
        end
    endtask

    // Full count sweep for every kind over several operand patterns (R3..R9).
    task automatic t_sweep();
        logic [31:0] pats [6] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hDEAD_BEEF,
                                  32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0001};
        for (int p = 0; p < 6; p++)
            for (int k = 0; k < 3; k++)
                for (int n = 0; n < 64; n++)
                    apply_and_check(pats[p], 32'(n), 2'(k), n[0], tag_for(2'(k), n));
    endtask

    // Zero count holds the previous carry both ways (R2).
    task automatic t_zero_count();
        for (int k = 0; k < 3; k++) begin
            apply_and_check(32'hA5A5_0F0F, 32'd0, 2'(k), 1'b1, "R2");
            apply_and_check(32'hA5A5_0F0F, 32'd0, 2'(k), 1'b0, "R2");
        end
    endtask

    // Upper count bits are ignored: compare against the masked count (R1).
    task automatic t_count_high_bits();
        int cnts [5] = '{64, 65, 96, 127, 32'h8000_0021};
        for (int k = 0; k < 3; k++)
            for (int i = 0; i < 5; i++) begin
                apply_and_check(32'hC001_D00D, 32'(cnts[i]), 2'(k), 1'b1, "R1");
                checks++;
                if (32'(cnts[i]) == 32'd64 && (result !== 32'hC001_D00D || carry !== 1'b1)) begin
                    failures++;
                    $display("FAIL R1 count 64 kind=%0d: result=%h carry=%b expected C001D00D 1",
                             k, result, carry);
                end
            end
    endtask

    // Reserved kind passes the operand and holds the flags for any count (R10).
    task automatic t_reserved();
        int cnts [4] = '{0, 5, 32, 47};
        for (int i = 0; i < 4; i++) begin
            apply_and_check(32'h8765_4321, 32'(cnts[i]), 2'b11, 1'b1, "R10");
            apply_and_check(32'h8765_4321, 32'(cnts[i]), 2'b11, 1'b0, "R10");
        end
    endtask

    // Hand-worked boundary values.
    task automatic t_boundaries();
        @(negedge clk);
        operand = 32'h0000_0001; count = 32'd32; kind = 2'b00; cprev = 1'b0;
        #1; checks++;
        if (result !== 32'h0 || carry !== 1'b1) begin
            failures++;
            $display("FAIL R4 lsl 32: result=%h carry=%b expected 00000000 1", result, carry);
        end
        @(negedge clk);
        operand = 32'h8000_0000; count = 32'd32; kind = 2'b01; cprev = 1'b0;
        #1; checks++;
        if (result !== 32'h0 || carry !== 1'b1) begin
            failures++;
            $display("FAIL R6 lsr 32: result=%h carry=%b expected 00000000 1", result, carry);
        end
        @(negedge clk);
        operand = 32'h8000_0000; count = 32'd4; kind = 2'b10; cprev = 1'b1;
        #1; checks++;
        if (result !== 32'hF800_0000 || carry !== 1'b0 || extend !== 1'b0) begin
            failures++;
            $display("FAIL R7 asr 4: result=%h carry=%b extend=%b expected F8000000 0 0",
                     result, carry, extend);
        end
        @(negedge clk);
        operand = 32'h4000_0000; count = 32'd2; kind = 2'b00; cprev = 1'b0;
        #1; checks++;
        if (result !== 32'h0 || carry !== 1'b1) begin
            failures++;
            $display("FAIL R3 lsl 2: result=%h carry=%b expected 00000000 1", result, carry);
        end
        @(negedge clk);
        operand = 32'h0000_0004; count = 32'd3; kind = 2'b01; cprev = 1'b0;
        #1; checks++;
        if (result !== 32'h0 || carry !== 1'b1) begin
            failures++;
            $display("FAIL R5 lsr 3: result=%h carry=%b expected 00000000 1", result, carry);
        end
    endtask

    initial begin
        operand = '0; count = '0; kind = 2'b00; cprev = 1'b0;
        t_idle_state();
        t_zero_count();
        t_boundaries();
        t_reserved();
        t_count_high_bits();
        t_sweep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule